// File: doc/BRIEF.md
# Host Start/Poll Mailbox with Retry

This block sits between a host bus and an in-memory processor that can never act as bus master. The host launches work by writing a launch bit into a control register. It then learns of completion by reading a status register. Every transaction is started by the host, and the block only ever answers.

While the in-memory processor is still running, a status read is not answered with data. The block instead tells the memory controller to retry. The controller re-issues the read on its own, so the host sees a single read, and that read completes once the work has finished. A programmable retry limit bounds this wait. When the limit is reached, the block answers with a timeout status rather than asking for another retry. On the processor side there is a one-cycle launch pulse out and a one-cycle finish pulse in.

The register map uses three addresses: 0 for control, 1 for status and 2 for the retry limit. The status word carries four bits: bit 0 done, bit 1 running, bit 2 sticky error and bit 3 timeout. All upper bits read as zero.

Top module: `host_poll_mailbox`

## Requirements
- R1: After reset the block is idle, `bus_ack`, `bus_retry` and `pim_launch` are low, and a status read returns 0.
- R2: Each cycle with `bus_req` high gets exactly one response in the next cycle: either `bus_ack` or `bus_retry`, never both. Neither response is ever raised without a request in the cycle before.
- R3: A write to address 0 with bit 0 set, while idle or done, is acknowledged. It moves the block to running, clears done (status bit 0), and raises `pim_launch` for exactly one cycle.
- R4: A launch write while running is acknowledged but otherwise ignored: no `pim_launch` pulse and no change of run state. It sets the sticky error bit (status bit 2), which stays set until reset.
- R5: A status read while running, with the retry count below the limit, answers `bus_retry` with `bus_rdata` zero and increments the retry count.
- R6: A status read while running, with the retry count at or above the limit, answers `bus_ack` with timeout (bit 3) and running (bit 1) set, and restarts the retry count at zero. A launch also clears the count.
- R7: A `pim_finish` pulse while running moves the block to done. The next status read and every later one until the next launch is acknowledged at once, with bit 0 set.
- R8: A `pim_finish` pulse while idle or done has no effect on the status.
- R9: Address 2 holds the retry limit. It reads back what was last written and resets to `DEF_LIMIT`. With a limit of 0, the first status read while running returns the timeout status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Host-bus request valid for one cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address (0 control, 1 status, 2 limit) |
| bus_wdata | input | DATA_W | Write data |
| bus_ack | output | 1 | Request completed; `bus_rdata` is valid for reads |
| bus_retry | output | 1 | Memory controller must re-issue the read |
| bus_rdata | output | DATA_W | Read data, zero on retries and writes |
| pim_launch | output | 1 | One-cycle launch pulse to the in-memory processor |
| pim_finish | input | 1 | One-cycle completion pulse from the in-memory processor |

## Verification
The bench builds the block with a 4-bit retry counter, a 16-bit data path and a reset limit of 2. With these values the timeout path is reached after only a few polls, and the limit can be rewritten to 0 and to 5 within a short run. Rewriting the limit reaches the immediate-timeout corner and a longer retry chain. A launch write during a run and stray finish pulses in the idle and done states exercise the ignore paths, which are observed through later status reads.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } run_state_e;

  localparam logic [1:0] ADR_CTRL = 2'd0;
  localparam logic [1:0] ADR_STAT = 2'd1;
  localparam logic [1:0] ADR_LIM  = 2'd2;

  localparam int STAT_W = 4;

  // status word: {timeout, error, running, done}
  function automatic logic [STAT_W-1:0] pack_status(logic done, logic running,
                                                    logic err, logic tmo);
    return {tmo, err, running, done};
  endfunction

  // true when the retry budget is used up
  function automatic logic budget_spent(logic [31:0] cnt, logic [31:0] lim);
    return cnt >= lim;
  endfunction

endpackage

// File: rtl/mbx_seq.sv
module mbx_seq
  import mbx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       launch_req,
  input  logic       finish_in,
  output run_state_e state_o,
  output logic       launch_pulse_o,
  output logic       err_o,
  output logic       launch_ok_o
);

  run_state_e state_q;
  logic       pulse_q;
  logic       err_q;
  logic       launch_ok;
  logic       launch_bad;

  assign launch_ok  = launch_req && (state_q != ST_RUN);
  assign launch_bad = launch_req && (state_q == ST_RUN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pulse_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      pulse_q <= launch_ok;
      if (launch_bad) err_q <= 1'b1;
      if (launch_ok) begin
        state_q <= ST_RUN;
      end else if (state_q == ST_RUN && finish_in) begin
        state_q <= ST_DONE;
      end
    end
  end

  assign state_o        = state_q;
  assign launch_pulse_o = pulse_q;
  assign err_o          = err_q;
  assign launch_ok_o    = launch_ok;

  AST_FINISH_TO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && finish_in) |=> (state_q == ST_DONE)); // R7
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q); // R4
  AST_BAD_LAUNCH_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    launch_bad |=> (!pulse_q && state_q != ST_IDLE && err_q)); // R4
  AST_STRAY_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_RUN && finish_in && !launch_req) |=> $stable(state_q)); // R8

endmodule

// File: rtl/mbx_retry.sv
module mbx_retry
  import mbx_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             poll_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             retry_o,
  output logic             timeout_o
);

  logic [CNT_W-1:0] cnt_q;
  logic             spent;

  assign spent     = budget_spent(32'(cnt_q), 32'(limit_i));
  assign retry_o   = poll_i && !spent;
  assign timeout_o = poll_i && spent;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clear_i) begin
      cnt_q <= '0;
    end else if (poll_i) begin
      cnt_q <= spent ? '0 : cnt_q + 1'b1;
    end
  end

  AST_TIMEOUT_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |=> (cnt_q == '0)); // R6
  AST_RETRY_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
    (retry_o && !clear_i) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R5
  AST_NO_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    !(retry_o && timeout_o)); // R2

endmodule

// File: rtl/host_poll_mailbox.sv
module host_poll_mailbox
  import mbx_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int CNT_W     = 8,
  parameter int DEF_LIMIT = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              bus_ack,
  output logic              bus_retry,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              pim_launch,
  input  logic              pim_finish
);

  localparam int STAT_PAD = DATA_W - STAT_W;
  localparam int LIM_PAD  = DATA_W - CNT_W;

  run_state_e       state;
  logic             err_flag;
  logic             launch_ok;
  logic             launch_req;
  logic             lim_wr;
  logic             stat_rd;
  logic             poll_run;
  logic             retry_now;
  logic             timeout_now;
  logic [CNT_W-1:0] limit_q;
  logic [DATA_W-1:0] rd_mux;
  logic [STAT_W-1:0] stat_word;

  assign launch_req = bus_req && bus_wr && bus_addr == ADR_CTRL && bus_wdata[0];
  assign lim_wr     = bus_req && bus_wr && bus_addr == ADR_LIM;
  assign stat_rd    = bus_req && !bus_wr && bus_addr == ADR_STAT;
  assign poll_run   = stat_rd && state == ST_RUN;

  mbx_seq u_seq (
    .clk            (clk),
    .rst_n          (rst_n),
    .launch_req     (launch_req),
    .finish_in      (pim_finish),
    .state_o        (state),
    .launch_pulse_o (pim_launch),
    .err_o          (err_flag),
    .launch_ok_o    (launch_ok)
  );

  mbx_retry #(.CNT_W(CNT_W)) u_retry (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear_i   (launch_ok),
    .poll_i    (poll_run),
    .limit_i   (limit_q),
    .retry_o   (retry_now),
    .timeout_o (timeout_now)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) limit_q <= CNT_W'(DEF_LIMIT);
    else if (lim_wr) limit_q <= bus_wdata[CNT_W-1:0];
  end

  assign stat_word = pack_status(state == ST_DONE, state == ST_RUN, err_flag, timeout_now);

  always_comb begin
    rd_mux = '0;
    if (!bus_wr) begin
      case (bus_addr)
        ADR_STAT: rd_mux = {{STAT_PAD{1'b0}}, stat_word};
        ADR_LIM:  rd_mux = {{LIM_PAD{1'b0}}, limit_q};
        default:  rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_ack   <= 1'b0;
      bus_retry <= 1'b0;
      bus_rdata <= '0;
    end else begin
      bus_ack   <= bus_req && !retry_now;
      bus_retry <= retry_now;
      bus_rdata <= (bus_req && !retry_now) ? rd_mux : '0;
    end
  end

  AST_ONE_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_ack && bus_retry)); // R2
  AST_NO_UNSOLICITED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ack || bus_retry) |-> $past(bus_req)); // R2
  AST_REQ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |=> (bus_ack || bus_retry)); // R2
  AST_RETRY_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    bus_retry |-> (bus_rdata == '0)); // R5
  AST_DONE_NO_RETRY: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && state == ST_DONE) |=> (bus_ack && bus_rdata[0])); // R7
  AST_LAUNCH_FROM_HOST: assert property (@(posedge clk) disable iff (!rst_n)
    pim_launch |-> $past(bus_req && bus_wr)); // R3

endmodule

// File: tb/sim_host_poll_mailbox.sv
`timescale 1ns/1ps
module sim_host_poll_mailbox;

  localparam int DW = 16;
  localparam int CW = 4;
  localparam int DL = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_req = 1'b0;
  logic          bus_wr = 1'b0;
  logic [1:0]    bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic          bus_ack;
  logic          bus_retry;
  logic [DW-1:0] bus_rdata;
  logic          pim_launch;
  logic          pim_finish = 1'b0;

  always #2 clk = ~clk;

  host_poll_mailbox #(.DATA_W(DW), .CNT_W(CW), .DEF_LIMIT(DL)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
    .bus_retry(bus_retry), .bus_rdata(bus_rdata), .pim_launch(pim_launch),
    .pim_finish(pim_finish)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  // expected response: {retry, data}
  logic [DW:0] exp_q[$];
  string       tag_q[$];

  // independent model
  int m_state = 0; // 0 idle, 1 running, 2 done
  bit m_err = 0;
  int m_cnt = 0;
  int m_lim = DL;

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  function automatic logic [DW-1:0] stat_exp(bit tmo);
    logic [DW-1:0] s = '0;
    s[0] = (m_state == 2);
    s[1] = (m_state == 1);
    s[2] = m_err;
    s[3] = tmo;
    return s;
  endfunction

  // monitor: compares every response with the scoreboard
  always @(posedge clk) begin
    #1;
    if (rst_n && (bus_ack || bus_retry)) begin
      if (exp_q.size() == 0) begin
        chk(0, "R2 unsolicited", {bus_retry, bus_rdata}, 0);
      end else begin
        logic [DW:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(bus_ack != bus_retry && {bus_retry, bus_rdata} == e, t,
            {15'd0, bus_retry, bus_rdata}, {15'd0, e});
      end
    end
  end

  task automatic bus_op(bit wr, logic [1:0] addr, logic [DW-1:0] wd, string tag);
    bit exp_launch = 0;
    @(negedge clk);
    bus_req = 1; bus_wr = wr; bus_addr = addr; bus_wdata = wd;
    if (wr) begin
      exp_q.push_back({1'b0, {DW{1'b0}}}); tag_q.push_back(tag);
      if (addr == 2'd0 && wd[0]) begin
        if (m_state == 1) m_err = 1;
        else begin m_state = 1; m_cnt = 0; exp_launch = 1; end
      end else if (addr == 2'd2) m_lim = int'(wd[CW-1:0]);
    end else if (addr == 2'd1) begin
      if (m_state == 1) begin
        if (m_cnt >= m_lim) begin
          exp_q.push_back({1'b0, stat_exp(1)}); m_cnt = 0;
        end else begin
          exp_q.push_back({1'b1, {DW{1'b0}}}); m_cnt++;
        end
      end else exp_q.push_back({1'b0, stat_exp(0)});
      tag_q.push_back(tag);
    end else if (addr == 2'd2) begin
      exp_q.push_back({1'b0, DW'(m_lim)}); tag_q.push_back(tag);
    end else begin
      exp_q.push_back({1'b0, {DW{1'b0}}}); tag_q.push_back(tag);
    end
    @(negedge clk);
    bus_req = 0; bus_wr = 0;
    if (wr && addr == 2'd0 && wd[0])
      chk(pim_launch == exp_launch, exp_launch ? "R3 launch pulse" : "R4 no launch",
          {31'd0, pim_launch}, {31'd0, exp_launch});
    @(negedge clk);
    if (wr && addr == 2'd0 && wd[0])
      chk(pim_launch == 0, "R3 single-cycle pulse", {31'd0, pim_launch}, 0);
  endtask

  task automatic finish_pulse();
    @(negedge clk);
    pim_finish = 1;
    if (m_state == 1) m_state = 2;
    @(negedge clk);
    pim_finish = 0;
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!bus_ack && !bus_retry && !pim_launch, "R1 reset outputs",
        {29'd0, bus_ack, bus_retry, pim_launch}, 0);
    rst_n = 1;
    bus_op(0, 2'd1, 0, "R1 idle status");
    bus_op(0, 2'd2, 0, "R9 reset limit");
    finish_pulse();
    bus_op(0, 2'd1, 0, "R8 finish in idle ignored");
    // run with limit 2: two retries, then timeout
    bus_op(1, 2'd0, 16'h1, "R3 launch ack");
    bus_op(0, 2'd1, 0, "R5 retry 1");
    bus_op(0, 2'd1, 0, "R5 retry 2");
    bus_op(0, 2'd1, 0, "R6 timeout");
    bus_op(0, 2'd1, 0, "R6 count restarted");
    bus_op(1, 2'd0, 16'h1, "R4 launch while running");
    bus_op(1, 2'd1, 16'hFFFF, "R2 write to status");
    bus_op(0, 2'd1, 0, "R5 retry after bad launch");
    bus_op(0, 2'd1, 0, "R4 timeout shows error");
    finish_pulse();
    bus_op(0, 2'd1, 0, "R7 first read done");
    bus_op(0, 2'd1, 0, "R7 done persists");
    finish_pulse();
    bus_op(0, 2'd1, 0, "R8 finish in done ignored");
    // limit 0: immediate timeout
    bus_op(1, 2'd2, 16'h0, "R9 limit write");
    bus_op(0, 2'd2, 0, "R9 limit readback 0");
    bus_op(1, 2'd0, 16'h1, "R3 relaunch from done");
    bus_op(0, 2'd1, 0, "R9 zero limit timeout");
    finish_pulse();
    bus_op(0, 2'd1, 0, "R7 done after zero limit");
    // limit 5: longer chain
    bus_op(1, 2'd2, 16'h5, "R9 limit write 5");
    bus_op(0, 2'd2, 0, "R9 limit readback 5");
    bus_op(1, 2'd0, 16'h1, "R3 launch limit 5");
    for (int i = 0; i < 5; i++) bus_op(0, 2'd1, 0, "R5 long retry chain");
    bus_op(0, 2'd1, 0, "R6 timeout at 5");
    bus_op(0, 2'd1, 0, "R5 retry after timeout");
    finish_pulse();
    bus_op(0, 2'd1, 0, "R7 single read done");
    bus_op(1, 2'd0, 16'h0, "R3 control write without launch bit");
    bus_op(0, 2'd1, 0, "R3 still done");
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R2 all requests answered", exp_q.size(), 0);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule